// File: doc/BRIEF.md
# Floating-Point Min/Max Unit

This block picks the larger or smaller of two single-precision floating-point operands. A two-bit opcode chooses between plain maximum, plain minimum, and the number-preferring maximum and minimum. The plain forms let any NaN reach the output. The number-preferring forms skip over a lone quiet NaN and return the numeric operand. A signaling NaN on either input wins in every mode and leaves the unit in quieted form. Zeros are ordered by sign, so positive zero sits above negative zero.

A default-NaN control input replaces any NaN result with one canonical quiet NaN. A flush-to-zero control input is accepted for interface compatibility and leaves every result unchanged. By default the result passes through an output register that loads only when an input is flagged valid. The output valid flag follows the input valid flag by one clock.

Top module: `fpmm_unit`

## Requirements
- R1: The opcode selects the operation: 2'b00 maximum, 2'b01 minimum, 2'b10 maximum-number, 2'b11 minimum-number. For two non-NaN operands, every operation returns the larger (maximum forms) or smaller (minimum forms) operand, with infinities at the ends of the ordering.
- R2: Positive zero (0x00000000) orders above negative zero (0x80000000). Maximum returns +0 and minimum returns -0 in either operand order.
- R3: If exactly one operand is a signaling NaN, every operation returns it quieted. A NaN has exponent bits 30:23 all ones and a non-zero mantissa 22:0. It is signaling when bit 22 is clear. Quieting sets bit 22 and keeps the sign and the other payload bits.
- R4: A signaling NaN outranks a quiet NaN in either operand order. The result is the signaling operand, quieted.
- R5: When both operands are signaling NaNs, the result is operand A quieted. When both are quiet NaNs, the result is operand A unchanged.
- R6: For opcodes 00 and 01, a quiet NaN paired with a number (infinities included) is returned as it is.
- R7: For opcodes 10 and 11, a quiet NaN paired with a number yields the number.
- R8: With the default-NaN input high, any NaN result is replaced by 0x7fc00000. Non-NaN results are unchanged.
- R9: The flush-to-zero input has no effect on any result, denormal operands included.
- R10: The output register resets `out_valid` and `result` to 0. `out_valid` is `in_valid` delayed by one clock. `result` loads only on cycles with `in_valid` high and holds otherwise.
- R11: A NaN result on the output is never signaling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op | input | 2 | Operation select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| dn_mode | input | 1 | Default-NaN substitution enable |
| ftz_mode | input | 1 | Flush-to-zero request (no effect) |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Selected value |

## Verification
The hardest cases to reach are operand pairs where the order of the inputs decides the outcome. These are two NaNs of the same kind, or two NaNs of different kinds presented in either order. Only rare bit patterns in the exponent and the mantissa's top bit get there. The vector table therefore pairs quiet and signaling NaNs with distinct payloads and signs. Every pair that should be order-independent is run in both operand orders under all four default-NaN and flush-to-zero combinations, while the same-kind NaN pairs are run only in their stated order.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
   typedef enum logic [1:0] {
      FPMM_MAX    = 2'b00,
      FPMM_MIN    = 2'b01,
      FPMM_MAXNUM = 2'b10,
      FPMM_MINNUM = 2'b11
   } fpmm_op_e;
endpackage

// File: rtl/fpmm_classify.sv
// Operand classification: NaN detection, signaling test, quieted copy.
module fpmm_classify #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] val,
   output logic                 is_nan,
   output logic                 is_snan,
   output logic [EXP_W+MAN_W:0] quieted
);
   localparam int W = 1 + EXP_W + MAN_W;
   localparam logic [W-1:0] QBIT = {{(W-MAN_W){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic exp_ones;
   logic man_nz;

   always_comb begin
      exp_ones = &val[W-2:MAN_W];
      man_nz   = |val[MAN_W-1:0];
      is_nan   = exp_ones & man_nz;
      is_snan  = is_nan & ~val[MAN_W-1];
      quieted  = val | QBIT;
   end
endmodule

// File: rtl/fpmm_order.sv
// Sign-magnitude ordering without subtraction; +0 ranks above -0.
module fpmm_order #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   output logic                 a_gt_b
);
   localparam int W = 1 + EXP_W + MAN_W;

   logic mag_a_gt;
   logic mag_b_gt;

   always_comb begin
      mag_a_gt = a[W-2:0] > b[W-2:0];
      mag_b_gt = b[W-2:0] > a[W-2:0];
      if (a[W-1] != b[W-1])
         a_gt_b = ~a[W-1];
      else if (a[W-1])
         a_gt_b = mag_b_gt;
      else
         a_gt_b = mag_a_gt;
   end
endmodule

// File: rtl/fpmm_select.sv
// NaN priority resolution and final pick between operands.
module fpmm_select
   import fpmm_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  fpmm_op_e             op,
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   input  logic                 a_nan,
   input  logic                 a_snan,
   input  logic [EXP_W+MAN_W:0] a_quiet,
   input  logic                 b_nan,
   input  logic                 b_snan,
   input  logic [EXP_W+MAN_W:0] b_quiet,
   input  logic                 a_gt_b,
   output logic [EXP_W+MAN_W:0] res
);
   logic num_pref;
   logic want_max;

   always_comb begin
      num_pref = (op == FPMM_MAXNUM) || (op == FPMM_MINNUM);
      want_max = (op == FPMM_MAX) || (op == FPMM_MAXNUM);
      if (a_snan)
         res = a_quiet;
      else if (b_snan)
         res = b_quiet;
      else if (a_nan && b_nan)
         res = a;
      else if (a_nan)
         res = num_pref ? b : a;
      else if (b_nan)
         res = num_pref ? a : b;
      else
         res = (a_gt_b == want_max) ? a : b;
   end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
   import fpmm_pkg::*;
#(
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [1:0]           op,
   input  logic [EXP_W+MAN_W:0] opnd_a,
   input  logic [EXP_W+MAN_W:0] opnd_b,
   input  logic                 dn_mode,
   input  logic                 ftz_mode,
   output logic                 out_valid,
   output logic [EXP_W+MAN_W:0] result
);
   localparam int W = 1 + EXP_W + MAN_W;
   localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   if (EXP_W < 2) begin : g_bad_exp
      $error("fpmm_unit: EXP_W must be at least 2");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("fpmm_unit: MAN_W must be at least 2");
   end

   logic ftz_unused;
   assign ftz_unused = ftz_mode;

   logic         a_nan, a_snan, b_nan, b_snan;
   logic [W-1:0] a_quiet, b_quiet;
   logic         a_gt_b;
   logic [W-1:0] raw_res;
   logic         raw_nan;
   logic         raw_snan_unused;
   logic [W-1:0] raw_quiet_unused;
   logic [W-1:0] final_res;

   fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
      .val(opnd_a), .is_nan(a_nan), .is_snan(a_snan), .quieted(a_quiet)
   );

   fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
      .val(opnd_b), .is_nan(b_nan), .is_snan(b_snan), .quieted(b_quiet)
   );

   fpmm_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
      .a(opnd_a), .b(opnd_b), .a_gt_b(a_gt_b)
   );

   fpmm_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_select (
      .op      (fpmm_op_e'(op)),
      .a       (opnd_a),
      .b       (opnd_b),
      .a_nan   (a_nan),
      .a_snan  (a_snan),
      .a_quiet (a_quiet),
      .b_nan   (b_nan),
      .b_snan  (b_snan),
      .b_quiet (b_quiet),
      .a_gt_b  (a_gt_b),
      .res     (raw_res)
   );

   fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_res (
      .val(raw_res), .is_nan(raw_nan), .is_snan(raw_snan_unused), .quieted(raw_quiet_unused)
   );

   always_comb begin
      final_res = (dn_mode && raw_nan) ? CANON_NAN : raw_res;
   end

   if (REGISTERED) begin : g_reg
      logic         vld_q;
      logic [W-1:0] res_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
         end else begin
            vld_q <= in_valid;
            if (in_valid)
               res_q <= final_res;
         end
      end
      assign out_valid = vld_q;
      assign result    = res_q;
   end else begin : g_comb
      logic clk_unused;
      assign clk_unused = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign result     = final_res;
   end
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker #(
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter bit REGISTERED = 1'b1
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 in_valid,
   input logic [1:0]           op,
   input logic [EXP_W+MAN_W:0] opnd_a,
   input logic [EXP_W+MAN_W:0] opnd_b,
   input logic                 dn_mode,
   input logic                 ftz_mode,
   input logic                 out_valid,
   input logic [EXP_W+MAN_W:0] result
);
   localparam int W = 1 + EXP_W + MAN_W;
   localparam logic [W-1:0] QBIT  = {{(W-MAN_W){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
   localparam logic [W-1:0] NEG_Z = {1'b1, {(W-1){1'b0}}};

   function automatic logic nan_f(input logic [W-1:0] v);
      return (&v[W-2:MAN_W]) && (|v[MAN_W-1:0]);
   endfunction

   function automatic logic snan_f(input logic [W-1:0] v);
      return nan_f(v) && !v[MAN_W-1];
   endfunction

   logic ftz_unused;
   assign ftz_unused = ftz_mode;

   if (REGISTERED) begin : g_chk
      a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid);
      a_r10_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !out_valid);
      a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(result));
      a_r8_default_nan: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && dn_mode) |=> (!nan_f(result) || result == CANON));
      a_r3_snan_a: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && snan_f(opnd_a) && !dn_mode) |=> result == ($past(opnd_a) | QBIT));
      a_r2_zero_max: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && op == 2'b00 && opnd_a == '0 && opnd_b == NEG_Z) |=> result == '0);
      a_r11_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> !snan_f(result));
   end else begin : g_chk_comb
      logic unused_sig;
      assign unused_sig = ^{clk, rst_n, op, opnd_b, out_valid};
      always_comb begin
         if (in_valid && !dn_mode && snan_f(opnd_a))
            a_r3_snan_a_comb: assert (result == (opnd_a | QBIT));
         if (in_valid)
            a_r11_quiet_comb: assert (!snan_f(result));
      end
   end
endmodule

bind fpmm_unit fpmm_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W), .REGISTERED(REGISTERED)) u_fpmm_chk (.*);

// File: tb/tb_fpmm_unit.sv
`timescale 1ns/1ps
module tb_fpmm_unit;
   typedef struct packed {
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] e_max;
      logic [31:0] e_min;
      logic [31:0] e_maxn;
      logic [31:0] e_minn;
      logic        one_way;
   } vec_t;

   localparam int NV = 16;
   localparam logic [31:0] CANON = 32'h7fc00000;

   // Expected columns: max, min, max-number, min-number.
   localparam vec_t VECS [NV] = '{
      '{32'h00000000, 32'h80000000, 32'h00000000, 32'h80000000, 32'h00000000, 32'h80000000, 1'b0}, // R2
      '{32'h3f800000, 32'hbf800000, 32'h3f800000, 32'hbf800000, 32'h3f800000, 32'hbf800000, 1'b0}, // R1
      '{32'h40000000, 32'h3f800000, 32'h40000000, 32'h3f800000, 32'h40000000, 32'h3f800000, 1'b0}, // R1
      '{32'hc0000000, 32'hc0400000, 32'hc0000000, 32'hc0400000, 32'hc0000000, 32'hc0400000, 1'b0}, // R1
      '{32'h3f800000, 32'h7f800000, 32'h7f800000, 32'h3f800000, 32'h7f800000, 32'h3f800000, 1'b0}, // R1
      '{32'h7f800000, 32'hff800000, 32'h7f800000, 32'hff800000, 32'h7f800000, 32'hff800000, 1'b0}, // R1
      '{32'hff800000, 32'hbf800000, 32'hbf800000, 32'hff800000, 32'hbf800000, 32'hff800000, 1'b0}, // R1
      '{32'h3f800000, 32'h7fc00011, 32'h7fc00011, 32'h7fc00011, 32'h3f800000, 32'h3f800000, 1'b0}, // R6 R7
      '{32'hff800000, 32'hffc00005, 32'hffc00005, 32'hffc00005, 32'hff800000, 32'hff800000, 1'b0}, // R6 R7
      '{32'h3f800000, 32'h7f800023, 32'h7fc00023, 32'h7fc00023, 32'h7fc00023, 32'h7fc00023, 1'b0}, // R3
      '{32'hc0a00000, 32'hff812345, 32'hffc12345, 32'hffc12345, 32'hffc12345, 32'hffc12345, 1'b0}, // R3
      '{32'h7fc00011, 32'h7f800023, 32'h7fc00023, 32'h7fc00023, 32'h7fc00023, 32'h7fc00023, 1'b0}, // R4
      '{32'h7fc00011, 32'hffc00002, 32'h7fc00011, 32'h7fc00011, 32'h7fc00011, 32'h7fc00011, 1'b1}, // R5
      '{32'h7f800023, 32'hff812345, 32'h7fc00023, 32'h7fc00023, 32'h7fc00023, 32'h7fc00023, 1'b1}, // R5
      '{32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h3f800000, 32'h3f800000, 1'b0}, // R1
      '{32'h00000001, 32'h00000000, 32'h00000001, 32'h00000000, 32'h00000001, 32'h00000000, 1'b0}  // R9
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        dn_mode = 1'b0;
   logic        ftz_mode = 1'b0;
   logic        out_valid;
   logic [31:0] result;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   fpmm_unit dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .dn_mode(dn_mode), .ftz_mode(ftz_mode),
      .out_valid(out_valid), .result(result)
   );

   function automatic logic is_nan32(input logic [31:0] v);
      return (v[30:23] == 8'hff) && (v[22:0] != 0);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Presents one operation and samples the registered output one clock later.
   task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic dn, input logic ftz);
      @(negedge clk);
      in_valid = 1'b1; op = o; opnd_a = a; opnd_b = b; dn_mode = dn; ftz_mode = ftz;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   function automatic logic [31:0] pick(input vec_t v, input int o, input logic dn);
      logic [31:0] e;
      case (o)
         0: e = v.e_max;
         1: e = v.e_min;
         2: e = v.e_maxn;
         default: e = v.e_minn;
      endcase
      return (dn && is_nan32(e)) ? CANON : e;
   endfunction

   initial begin
      #500000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      chk("R10 reset out_valid", {31'b0, out_valid}, 32'd0);
      chk("R10 reset result", result, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: all opcodes, both orders, all control combinations.
      for (int i = 0; i < NV; i++) begin
         for (int o = 0; o < 4; o++) begin
            for (int m = 0; m < 4; m++) begin
               for (int sw = 0; sw < 2; sw++) begin
                  if (sw == 1 && VECS[i].one_way) continue;
                  if (sw == 0)
                     run_op(o[1:0], VECS[i].a, VECS[i].b, m[0], m[1]);
                  else
                     run_op(o[1:0], VECS[i].b, VECS[i].a, m[0], m[1]);
                  chk($sformatf("R1-table vec%0d op%0d dn%0d ftz%0d swap%0d", i, o, m[0], m[1], sw),
                      result, pick(VECS[i], o, m[0]));
               end
            end
         end
      end

      // R10: valid follows input valid; result holds when idle.
      run_op(2'b00, 32'h40400000, 32'h3f800000, 1'b0, 1'b0);
      chk("R10 out_valid after input", {31'b0, out_valid}, 32'd1);
      held = result;
      chk("R1 max of 3 and 1", held, 32'h40400000);
      opnd_a = 32'hc1000000; opnd_b = 32'hc2000000; op = 2'b01;
      @(negedge clk);
      chk("R10 out_valid idle", {31'b0, out_valid}, 32'd0);
      chk("R10 result held while idle", result, held);

      // R11: quieted output of a minimal-payload signaling NaN.
      run_op(2'b11, 32'h7f800001, 32'h3f800000, 1'b0, 1'b0);
      chk("R11 quiet bit set", result, 32'h7fc00001);
      run_op(2'b10, 32'h3f800000, 32'hff800001, 1'b0, 1'b0);
      chk("R3 negative sNaN in B", result, 32'hffc00001);

      // R8: non-NaN result unchanged under default-NaN.
      run_op(2'b01, 32'hbf800000, 32'h3f800000, 1'b1, 1'b0);
      chk("R8 non-NaN kept", result, 32'hbf800000);
      run_op(2'b00, 32'hffc00009, 32'h3f800000, 1'b1, 1'b0);
      chk("R8 NaN replaced", result, CANON);

      // R6 / R7 against infinity.
      run_op(2'b01, 32'h7f800000, 32'h7fc00041, 1'b0, 1'b0);
      chk("R6 min qNaN with +Inf", result, 32'h7fc00041);
      run_op(2'b11, 32'h7f800000, 32'h7fc00041, 1'b0, 1'b0);
      chk("R7 min-number qNaN with +Inf", result, 32'h7f800000);

      // R9: flush-to-zero with a negative denormal.
      run_op(2'b01, 32'h80000003, 32'h00000000, 1'b0, 1'b1);
      chk("R9 denormal kept under ftz", result, 32'h80000003);

      // R2: zeros in reversed order under min-number.
      run_op(2'b11, 32'h80000000, 32'h00000000, 1'b0, 1'b0);
      chk("R2 min-number of -0,+0", result, 32'h80000000);

      // R4 / R5 spot checks in reverse order.
      run_op(2'b10, 32'h7f800023, 32'h7fc00011, 1'b0, 1'b0);
      chk("R4 sNaN first, qNaN second", result, 32'h7fc00023);
      run_op(2'b00, 32'hffc00002, 32'h7fc00011, 1'b0, 1'b0);
      chk("R5 two qNaN, A wins", result, 32'hffc00002);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule